// File: doc/BRIEF.md
# Time-Encoded Chunk Transmitter

This block sends a data word as a set of pulse timings rather than wire levels. The word is cut into four-bit chunks, and each chunk owns one data wire. An accepted start flips a shared reference wire to open a window. Each chunk then flips its own wire exactly once, and the number of clock edges between the reference flip and that flip carries the chunk value. A receiver with a matching counter recovers the value without counting wire levels.

To save wire flips, chunks can be suppressed. In zero mode, zero chunks stay silent. In last-value mode, a chunk equal to the previous value sent on its wire stays silent. In both modes the suppressed value is taken out of the count sequence, so values above it arrive one edge earlier. Once every unsuppressed chunk has fired, the reference wire flips a second time to close the window. The receiver loads the suppressed value into every chunk that stayed silent. The upstream controller sees a ready/start handshake and a one-cycle done pulse.

Top module: `pulse_time_tx`

## Requirements
- R1: After reset, `rs_wire` and all `data_wires` are 0, `ready` is 1 and `done` is 0.
- R2: A start sampled high while `ready` is high is accepted at that clock edge. At the same edge `rs_wire` flips and `ready` falls, and no data wire flips at that edge.
- R3: When `mode` is 0 (no skipping) or 3 (treated as 0), chunk w is `data_in[4w+3:4w]`. A chunk of value v flips data wire w exactly once, at the (v+1)-th clock edge after the accepting edge.
- R4: When `mode` is 1 (zero skipping), a zero chunk never flips its wire. A nonzero value v flips its wire exactly once, at the v-th edge after the accepting edge.
- R5: When `mode` is 2 (last-value skipping), the skip value s of a wire is the last chunk accepted for that wire, or 0 if none has been accepted since reset. A chunk equal to s does not flip its wire. A chunk v below s flips at edge v+1, and a chunk v above s flips at edge v.
- R6: `rs_wire` flips again one edge after the last data-wire flip of the window. If every chunk was skipped, it flips at the first edge after the accepting edge.
- R7: `done` is high for exactly one cycle. It rises at the edge that closes the window, and `ready` returns high at that same edge.
- R8: A start asserted while `ready` is low has no effect on any wire or on the window timing.
- R9: `data_in` and `mode` are sampled only at the accepting edge. Later changes have no effect on the window in progress.
- R10: The per-wire history used by R5 records every accepted chunk, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send `data_in` |
| mode | input | 2 | Skip mode: 0 none, 1 zero, 2 last value, 3 none |
| data_in | input | 64 | Word to send; chunk w in bits 4w+3..4w |
| ready | output | 1 | High when a start will be accepted |
| done | output | 1 | One-cycle pulse at window close |
| rs_wire | output | 1 | Shared reference wire, flips at open and close |
| data_wires | output | 16 | One toggle-signalled wire per chunk |

## Verification
A wrong down-counter load or decrement shows up as a data-wire flip at the wrong edge, within at most 16 cycles of the accepting edge. A stale or missed pending flag shows up either as a missing flip or as a closing flip and done pulse at the wrong edge. A corrupted last-value history shows no error at all until the next last-value window, where a wire flips when it should stay silent, or the reverse. The bench therefore chains last-value windows directly after windows in other modes.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int CHUNK_W = 4;

    typedef enum logic [1:0] {
        SKIP_NONE = 2'd0,
        SKIP_ZERO = 2'd1,
        SKIP_LAST = 2'd2,
        SKIP_RSVD = 2'd3
    } skip_mode_e;

    typedef struct packed {
        logic [CHUNK_W-1:0] delay;
        logic               fire;
    } lane_plan_t;

    // Turn a chunk into its countdown and decide whether it is sent at all.
    function automatic lane_plan_t plan_chunk(input logic [CHUNK_W-1:0] val,
                                              input logic [CHUNK_W-1:0] prev,
                                              input skip_mode_e         m);
        lane_plan_t         p;
        logic               en;
        logic [CHUNK_W-1:0] sv;
        en      = (m == SKIP_ZERO) || (m == SKIP_LAST);
        sv      = (m == SKIP_ZERO) ? '0 : prev;
        p.fire  = !(en && (val == sv));
        p.delay = (en && (val > sv)) ? val - {{(CHUNK_W-1){1'b0}}, 1'b1} : val;
        return p;
    endfunction

endpackage

// File: rtl/ptx_lane.sv
module ptx_lane
    import ptx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  skip_mode_e         mode,
    input  logic [CHUNK_W-1:0] chunk,
    output logic               wire_q,
    output logic               pend_q
);
    logic [CHUNK_W-1:0] cnt_q;
    logic [CHUNK_W-1:0] last_q;
    lane_plan_t         plan;

    always_comb plan = plan_chunk(chunk, last_q, mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            wire_q <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            cnt_q  <= plan.delay;
            pend_q <= plan.fire;
            last_q <= chunk;
        end else if (pend_q) begin
            if (cnt_q == '0) begin
                wire_q <= ~wire_q;
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - {{(CHUNK_W-1){1'b0}}, 1'b1};
            end
        end
    end

    // R3
    lane_flip_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (wire_q != $past(wire_q)) |-> $past(pend_q));

    // R4
    lane_pending_ends_by_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> (wire_q != $past(wire_q)));

endmodule

// File: rtl/ptx_window.sv
module ptx_window (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic any_pend,
    output logic accept,
    output logic ready,
    output logic done,
    output logic rs_q
);
    logic busy_q;

    assign ready  = !busy_q;
    assign accept = start && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rs_q   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                rs_q   <= ~rs_q;
            end else if (busy_q && !any_pend) begin
                busy_q <= 1'b0;
                rs_q   <= ~rs_q;
                done   <= 1'b1;
            end
        end
    end

    // R7
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    pending_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> !ready);

    // R6
    rs_flip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_q != $past(rs_q)) |-> ($past(accept) || done));

endmodule

// File: rtl/pulse_time_tx.sv
module pulse_time_tx
    import ptx_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / CHUNK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] data_in,
    output logic              ready,
    output logic              done,
    output logic              rs_wire,
    output logic [LANES-1:0]  data_wires
);
    logic             accept;
    logic [LANES-1:0] pend;
    skip_mode_e       mode_e;

    assign mode_e = skip_mode_e'(mode);

    ptx_window u_window (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .any_pend (|pend),
        .accept   (accept),
        .ready    (ready),
        .done     (done),
        .rs_q     (rs_wire)
    );

    for (genvar w = 0; w < LANES; w++) begin : g_lane
        ptx_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (accept),
            .mode   (mode_e),
            .chunk  (data_in[w*CHUNK_W +: CHUNK_W]),
            .wire_q (data_wires[w]),
            .pend_q (pend[w])
        );
    end

    // R8
    idle_wires_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> $stable(data_wires));

    // R2
    open_no_data_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $stable(data_wires));

endmodule

// File: tb/pulse_time_tx_tb.sv
module pulse_time_tx_tb;

    typedef struct {
        int k;
        int idx;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] data_in = '0;
    logic        ready, done, rs_wire;
    logic [15:0] data_wires;

    int   checks = 0;
    int   failures = 0;
    ev_t  sb[$];
    logic [3:0] hist [16];

    always #4 clk = ~clk;

    pulse_time_tx u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .data_in(data_in),
        .ready(ready), .done(done), .rs_wire(rs_wire), .data_wires(data_wires)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor side: pop the matching expected item
    task automatic observe(input int k, input int idx, input string tag);
        int hit = -1;
        foreach (sb[i]) if (hit < 0 && sb[i].k == k && sb[i].idx == idx) hit = i;
        checks++;
        if (hit >= 0) sb.delete(hit);
        else begin
            failures++;
            $display("FAIL %s unexpected event on line %0d actual=%0d expected=none", tag, idx, k);
        end
    endtask

    task automatic run_window(input logic [63:0] d, input logic [1:0] m,
                              input bit poke, input string tag);
        logic [15:0] pw;
        logic        prs;
        int          maxk = 0;
        bit          any = 0;
        bit          seen = 0;
        int          close;
        @(negedge clk);
        while (!ready) @(negedge clk);
        // driver: expected schedule
        for (int w = 0; w < 16; w++) begin
            logic [3:0] v = d[4*w +: 4];
            bit         en = (m == 2'd1) || (m == 2'd2);
            logic [3:0] s = (m == 2'd1) ? 4'd0 : hist[w];
            if (!(en && v == s)) begin
                int c = (en && v > s) ? int'(v) - 1 : int'(v);
                sb.push_back('{c + 1, w});
                any = 1;
                if (c + 1 > maxk) maxk = c + 1;
            end
            hist[w] = v;
        end
        close = any ? maxk + 1 : 1;
        sb.push_back('{close, 16});
        sb.push_back('{close, 17});
        pw = data_wires;
        prs = rs_wire;
        start = 1'b1; data_in = d; mode = m;
        @(negedge clk);
        start = 1'b0;
        chk(rs_wire != prs, "R2", "reference flip at open", rs_wire, !prs);
        chk(ready == 1'b0, "R2", "ready after accept", ready, 0);
        chk(data_wires == pw, "R2", "data wires at open", data_wires, pw);
        prs = rs_wire;
        if (poke) begin
            start = 1'b1; data_in = ~d; mode = 2'd3 - m;
        end
        for (int k = 1; k <= 40 && !seen; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke) data_in = {d[31:0], d[63:32]};
            for (int w = 0; w < 16; w++)
                if (data_wires[w] != pw[w]) observe(k, w, poke ? "R9" : tag);
            if (rs_wire != prs) observe(k, 16, "R6");
            if (done) begin
                observe(k, 17, "R7");
                chk(ready == 1'b1, "R7", "ready at close", ready, 1);
                seen = 1;
            end
            pw = data_wires;
            prs = rs_wire;
        end
        foreach (sb[i]) begin
            checks++;
            failures++;
            $display("FAIL %s missing event on line %0d actual=none expected=%0d",
                     poke ? "R8" : tag, sb[i].idx, sb[i].k);
        end
        sb.delete();
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", done, 0);
        chk(data_wires == pw && rs_wire == prs, "R8", "idle quiet", data_wires, pw);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        foreach (hist[i]) hist[i] = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rs_wire == 1'b0 && data_wires == '0, "R1", "wires after reset", data_wires, 0);
        chk(ready == 1'b1 && done == 1'b0, "R1", "ready/done after reset", {ready, done}, 2);
        run_window(64'h0123_4567_89AB_CDEF, 2'd0, 1'b1, "R3");
        run_window(64'h00F0_1002_0000_300A, 2'd1, 1'b0, "R4");
        run_window(64'h0000_0000_0000_0000, 2'd1, 1'b0, "R4");
        run_window(64'h0000_5555_0000_1111, 2'd2, 1'b0, "R5");
        run_window(64'h1230_5655_F000_0211, 2'd2, 1'b1, "R5");
        run_window(64'h1230_5655_F000_0211, 2'd2, 1'b0, "R5");
        run_window(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, "R3");
        run_window(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, "R10");
        run_window(64'h8421_0F0F_7E3C_5A96, 2'd3, 1'b0, "R3");
        run_window(64'h8421_0F0F_7E3C_5A91, 2'd1, 1'b1, "R4");
        run_window(64'h9421_0F0E_7E3C_5A91, 2'd2, 1'b0, "R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule